// File: doc/BRIEF.md
# Hit Packet Assembler with Timer Injection

The block turns detector hit events into fixed 64-bit packets. Each hit arrives with a pixel address, a 14-bit coarse arrival time, a 10-bit time-over-threshold and a 4-bit fine arrival time. The block adds a 16-bit local coarse time taken from its own free-running 48-bit timer, so that the packet carries a 30-bit coarse timestamp at 25 ns steps. The local time supplies the upper 16 bits of that timestamp and the hit's arrival time supplies the lower 14 bits. Four fine bits of about 1.56 ns each refine it. The 30-bit coarse timestamp wraps after roughly 26.8 s.

To let software extend that range, the 48-bit timer runs at one count per 25 ns clock and wraps only after about 81 days. A sync pulse clears it. Once per interval (40,000,000 cycles, which is one second at 40 MHz, and settable through a parameter) the block snapshots the timer and inserts a timer packet into the same output stream. A distinct header marks that packet. The input and the output both use valid/ready handshakes. A single output register holds the packet being offered, and a pending timer packet always takes the output before a waiting hit.

Top module: `hit_pkt_asm`

## Requirements
- R1: While reset is held and on the first cycle after it, `pkt_valid_o` is 0 and `hit_ready_o` is 1.
- R2: A hit packet is {HIT_HDR (4'hB) in [63:60], address in [59:44], coarse arrival in [43:30], time-over-threshold in [29:20], fine arrival in [19:16], local time in [15:0]}.
- R3: The local time is bits [29:14] of the 48-bit timer, as the timer stands on the clock edge that accepts the hit.
- R4: The fine arrival value appears in [19:16] exactly as it was presented.
- R5: The timer advances by one on every clock edge on which sync is low, and it wraps modulo 2^48.
- R6: A sync pulse clears the timer to zero and restarts the injection interval.
- R7: On each interval tick, which comes SEC_CYCLES edges after the previous tick or after a sync, the timer value on that edge is captured. It is offered as {TMR_HDR (4'h4) in [63:60], 12 zero bits in [59:48], value in [47:0]}.
- R8: While a timer packet is pending, `hit_ready_o` is 0, and the timer packet is emitted before any waiting hit.
- R9: While `pkt_valid_o` is 1 and `pkt_ready_i` is 0, the packet holds stable and `hit_ready_o` is 0.
- R10: An accepted hit is offered on `pkt_valid_o` from the clock edge that accepts it, with no added latency. A timer packet is offered from the edge after its tick, provided the output is free on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Clears the timer and the interval counter |
| hit_valid_i | input | 1 | Hit event present |
| hit_ready_o | output | 1 | Hit accepted on this edge when valid |
| hit_addr_i | input | 16 | Pixel address |
| hit_toa_i | input | 14 | Coarse arrival time |
| hit_tot_i | input | 10 | Time over threshold |
| hit_ftoa_i | input | 4 | Fine arrival time |
| pkt_valid_o | output | 1 | Packet offered |
| pkt_ready_i | input | 1 | Downstream takes the packet |
| pkt_data_o | output | 64 | Packet contents |

## Verification
A hit accepted on one edge is visible at the next falling edge, one register later. A tick edge only marks the timer packet pending, so with a free output that packet appears at the second falling edge after the tick. The bench keeps its own model of the timer and the interval counter, updated on each rising edge from the requirements. It drives inputs and samples outputs only on falling edges, and it computes every expected local time and snapshot from that model at the exact edge where the design captures it. Stall and priority scenarios are aligned to a sync pulse so that the cycle on which the tick lands is known in advance.

// File: rtl/hit_pkt_asm.sv
module hit_pkt_asm #(
  parameter int ADDR_W     = 16,
  parameter int TOA_W      = 14,
  parameter int TOT_W      = 10,
  parameter int FTOA_W     = 4,
  parameter int LT_W       = 16,
  parameter int TMR_W      = 48,
  parameter int SEC_CYCLES = 40_000_000,
  parameter logic [3:0] HIT_HDR = 4'hB,
  parameter logic [3:0] TMR_HDR = 4'h4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      sync_i,
  input  logic                                      hit_valid_i,
  output logic                                      hit_ready_o,
  input  logic [ADDR_W-1:0]                         hit_addr_i,
  input  logic [TOA_W-1:0]                          hit_toa_i,
  input  logic [TOT_W-1:0]                          hit_tot_i,
  input  logic [FTOA_W-1:0]                         hit_ftoa_i,
  output logic                                      pkt_valid_o,
  input  logic                                      pkt_ready_i,
  output logic [4+ADDR_W+TOA_W+TOT_W+FTOA_W+LT_W-1:0] pkt_data_o
);
  localparam int PKT_W = 4 + ADDR_W + TOA_W + TOT_W + FTOA_W + LT_W;
  localparam int PAD_W = PKT_W - 4 - TMR_W;
  localparam int SEC_W = $clog2(SEC_CYCLES + 1);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_CYCLES - 1);

  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] snap_q;
  logic [SEC_W-1:0] sec_q;
  logic             pend_q;
  logic             tick;
  logic             out_free;

  assign tick        = !sync_i && (sec_q == SEC_LAST);
  assign out_free    = !pkt_valid_o || pkt_ready_i;
  assign hit_ready_o = out_free && !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n || sync_i) begin
      tmr_q <= '0;
      sec_q <= '0;
    end else begin
      tmr_q <= tmr_q + 1'b1;
      sec_q <= tick ? '0 : sec_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      snap_q <= '0;
    end else begin
      pend_q <= tick || (pend_q && !out_free);
      if (tick) snap_q <= tmr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_valid_o <= 1'b0;
      pkt_data_o  <= '0;
    end else if (out_free) begin
      if (pend_q) begin
        pkt_valid_o <= 1'b1;
        pkt_data_o  <= {TMR_HDR, {PAD_W{1'b0}}, snap_q};
      end else if (hit_valid_i) begin
        pkt_valid_o <= 1'b1;
        pkt_data_o  <= {HIT_HDR, hit_addr_i, hit_toa_i, hit_tot_i, hit_ftoa_i,
                        tmr_q[TOA_W +: LT_W]};
      end else begin
        pkt_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hit_pkt_asm_chk.sv
module hit_pkt_asm_chk #(
  parameter int PKT_W = 64,
  parameter int TMR_W = 48,
  parameter logic [3:0] HIT_HDR = 4'hB,
  parameter logic [3:0] TMR_HDR = 4'h4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_i,
  input logic             hit_ready_o,
  input logic             pkt_valid_o,
  input logic             pkt_ready_i,
  input logic [PKT_W-1:0] pkt_data_o,
  input logic [TMR_W-1:0] tmr_q
);
  localparam int PAD_W = PKT_W - 4 - TMR_W;

  AST_HOLD_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_data_o)); // R9
  AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && !pkt_ready_i |-> !hit_ready_o); // R9
  AST_HDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> (pkt_data_o[PKT_W-1 -: 4] == HIT_HDR) || (pkt_data_o[PKT_W-1 -: 4] == TMR_HDR)); // R2
  AST_TMR_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && (pkt_data_o[PKT_W-1 -: 4] == TMR_HDR) |-> pkt_data_o[PKT_W-5 -: PAD_W] == '0); // R7
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> tmr_q == '0); // R6
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> tmr_q == $past(tmr_q) + 1'b1); // R5
endmodule

bind hit_pkt_asm hit_pkt_asm_chk #(
  .PKT_W(PKT_W), .TMR_W(TMR_W), .HIT_HDR(HIT_HDR), .TMR_HDR(TMR_HDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .hit_ready_o(hit_ready_o),
  .pkt_valid_o(pkt_valid_o), .pkt_ready_i(pkt_ready_i),
  .pkt_data_o(pkt_data_o), .tmr_q(tmr_q)
);

// File: tb/hit_pkt_asm_bench.sv
`timescale 1ns/1ps
module hit_pkt_asm_bench;
  localparam int SEC = 300;
  localparam logic [3:0] HH = 4'hB;
  localparam logic [3:0] TH = 4'h4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0;
  logic hit_valid_i = 1'b0;
  logic hit_ready_o;
  logic [15:0] hit_addr_i = '0;
  logic [13:0] hit_toa_i = '0;
  logic [9:0]  hit_tot_i = '0;
  logic [3:0]  hit_ftoa_i = '0;
  logic pkt_valid_o;
  logic pkt_ready_i = 1'b1;
  logic [63:0] pkt_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [47:0] mtime = '0;
  logic [47:0] msnap = '0;
  int msec = 0;
  int mticks = 0;

  always #4 clk = ~clk;

  hit_pkt_asm #(.SEC_CYCLES(SEC)) u_hit_pkt_asm (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .hit_valid_i(hit_valid_i),
    .hit_ready_o(hit_ready_o), .hit_addr_i(hit_addr_i), .hit_toa_i(hit_toa_i),
    .hit_tot_i(hit_tot_i), .hit_ftoa_i(hit_ftoa_i), .pkt_valid_o(pkt_valid_o),
    .pkt_ready_i(pkt_ready_i), .pkt_data_o(pkt_data_o)
  );

  always @(posedge clk) begin
    if (!rst_n || sync_i) begin
      mtime <= '0;
      msec  <= 0;
    end else begin
      mtime <= mtime + 1'b1;
      if (msec == SEC - 1) begin
        msec   <= 0;
        msnap  <= mtime;
        mticks <= mticks + 1;
      end else begin
        msec <= msec + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_sync();
    @(negedge clk); sync_i = 1'b1;
    @(negedge clk); sync_i = 1'b0;
  endtask

  task automatic send_hit(input logic [15:0] a, input logic [13:0] t, input logic [9:0] o,
                          input logic [3:0] f);
    logic [47:0] tacc;
    logic [63:0] exp;
    @(negedge clk);
    hit_valid_i = 1'b1; hit_addr_i = a; hit_toa_i = t; hit_tot_i = o; hit_ftoa_i = f;
    while (!hit_ready_o) @(negedge clk);
    tacc = mtime;
    @(negedge clk);
    hit_valid_i = 1'b0;
    exp = {HH, a, t, o, f, tacc[29:14]};
    chk(pkt_valid_o == 1'b1, "R10", 64'(pkt_valid_o), 64'd1);
    chk(pkt_data_o == exp, "R2", pkt_data_o, exp);
    chk(pkt_data_o[19:16] == f, "R4", 64'(pkt_data_o[19:16]), 64'(f));
    chk(pkt_data_o[15:0] == tacc[29:14], "R3", 64'(pkt_data_o[15:0]), 64'(tacc[29:14]));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pkt_valid_o == 1'b0, "R1", 64'(pkt_valid_o), 64'd0);
    chk(hit_ready_o == 1'b1, "R1", 64'(hit_ready_o), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_valid_o == 1'b0, "R1", 64'(pkt_valid_o), 64'd0);
    chk(hit_ready_o == 1'b1, "R1", 64'(hit_ready_o), 64'd1);
  endtask

  task automatic t_patterns();
    do_sync();
    send_hit(16'hFFFF, 14'h3FFF, 10'h3FF, 4'hF);
    send_hit(16'h0000, 14'h0000, 10'h000, 4'h0);
    send_hit(16'hA5C3, 14'h1234, 10'h2AA, 4'h9);
  endtask

  task automatic t_backpressure();
    logic [63:0] held;
    logic [47:0] tacc;
    logic [63:0] exp;
    do_sync();
    pkt_ready_i = 1'b0;
    send_hit(16'h1111, 14'h0101, 10'h011, 4'h1);
    held = pkt_data_o;
    hit_valid_i = 1'b1; hit_addr_i = 16'h2222; hit_toa_i = 14'h0202;
    hit_tot_i = 10'h022; hit_ftoa_i = 4'h2;
    for (int i = 0; i < 3; i++) begin
      chk(hit_ready_o == 1'b0, "R9", 64'(hit_ready_o), 64'd0);
      chk(pkt_valid_o && pkt_data_o == held, "R9", pkt_data_o, held);
      @(negedge clk);
    end
    pkt_ready_i = 1'b1;
    tacc = mtime;
    @(negedge clk);
    hit_valid_i = 1'b0;
    exp = {HH, 16'h2222, 14'h0202, 10'h022, 4'h2, tacc[29:14]};
    chk(pkt_data_o == exp, "R9", pkt_data_o, exp);
  endtask

  task automatic t_timer();
    int t0;
    logic [47:0] first;
    logic [63:0] exp;
    do_sync();
    t0 = mticks;
    @(negedge clk);
    while (mticks == t0) @(negedge clk);
    chk(msnap == 48'(SEC - 1), "R6", 64'(msnap), 64'(SEC - 1));
    chk(!(pkt_valid_o && pkt_data_o[63:60] == TH), "R10", pkt_data_o, 64'd0);
    @(negedge clk);
    exp = {TH, 12'h000, msnap};
    chk(pkt_valid_o && pkt_data_o == exp, "R7", pkt_data_o, exp);
    first = pkt_data_o[47:0];
    t0 = mticks;
    while (mticks == t0) @(negedge clk);
    @(negedge clk);
    exp = {TH, 12'h000, first + 48'(SEC)};
    chk(pkt_valid_o && pkt_data_o == exp, "R5", pkt_data_o, exp);
  endtask

  task automatic t_priority();
    int t0;
    logic [47:0] tacc;
    logic [63:0] exp;
    do_sync();
    t0 = mticks;
    @(negedge clk);
    while (mticks == t0) @(negedge clk);
    hit_valid_i = 1'b1; hit_addr_i = 16'h3C3C; hit_toa_i = 14'h0333;
    hit_tot_i = 10'h133; hit_ftoa_i = 4'h3;
    chk(hit_ready_o == 1'b0, "R8", 64'(hit_ready_o), 64'd0);
    @(negedge clk);
    exp = {TH, 12'h000, msnap};
    chk(pkt_valid_o && pkt_data_o == exp, "R8", pkt_data_o, exp);
    chk(hit_ready_o == 1'b1, "R8", 64'(hit_ready_o), 64'd1);
    tacc = mtime;
    @(negedge clk);
    hit_valid_i = 1'b0;
    exp = {HH, 16'h3C3C, 14'h0333, 10'h133, 4'h3, tacc[29:14]};
    chk(pkt_valid_o && pkt_data_o == exp, "R8", pkt_data_o, exp);
  endtask

  task automatic t_local_time();
    do_sync();
    repeat (17000) @(negedge clk);
    send_hit(16'h0F0F, 14'h2468, 10'h155, 4'h6);
    chk(pkt_data_o[15:0] != 16'h0, "R3", 64'(pkt_data_o[15:0]), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_patterns();
    t_backpressure();
    t_timer();
    t_priority();
    t_local_time();
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule